// File: doc/BRIEF.md
# Soft Interrupt Pending Register

This block holds a vector of soft-interrupt pending flags and a processor interrupt level. From these it drives one level-sensitive request line per flag. Software changes the flags in one of three ways. It can load the whole vector, clear the flags named by a mask, or set the flags named by a mask. Two hardware timer-match pulses can also raise the lowest flag and the highest flag. Trap dispatch and handler selection live elsewhere. This block only says which levels are currently asking for service.

The vector has one flag for each level from 1 up to the top level. It also has two timer flags: the lowest flag (tick match) and the highest flag (system-tick match). An ordinary flag asks for service only when its index is strictly above the current level. The two timer flags use a fixed threshold instead: they ask only while the level is below a set limit. Every request line is recomputed from the stored flags and level. A line whose condition no longer holds drops in the same cycle that its condition fails.

Top module: `softint_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pending vector and the level both become zero, so every request line is low.
- R2: A software write with operation code 0 (load) replaces the whole pending vector with `sw_wr_data`.
- R3: A software write with operation code 1 (clear) stores the old vector ANDed with the inverse of `sw_wr_data`.
- R4: A software write with operation code 2 (set) stores the old vector ORed with `sw_wr_data`.
- R5: A software write with operation code 3 leaves the pending vector unchanged.
- R6: For every flag index k from 1 to 15, `irq_req[k]` is high exactly when flag k is set and k is strictly greater than the level.
- R7: `irq_req[0]` and `irq_req[16]` are each high exactly when their flag is set and the level is below 14.
- R8: `tick_hit` sets flag 0 and `stick_hit` sets flag 16 at the next edge. Each wins over a software load or clear of the same flag in the same cycle.
- R9: A level write stores `pil_wr_data`. It can happen in the same cycle as a flag write. The request lines reflect the new flags and level from the cycle after the edge, and they deassert as soon as their condition is false.
- R10: `pend_rd` and `pil_rd` return the stored vector and level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_en | input | 1 | Software write strobe for the pending vector |
| sw_wr_op | input | 2 | 0 load, 1 clear by mask, 2 set by mask, 3 no change |
| sw_wr_data | input | 17 | Write value or mask |
| pil_wr_en | input | 1 | Level write strobe |
| pil_wr_data | input | 4 | New level |
| tick_hit | input | 1 | Tick match pulse, sets flag 0 |
| stick_hit | input | 1 | System-tick match pulse, sets flag 16 |
| pend_rd | output | 17 | Stored pending vector |
| pil_rd | output | 4 | Stored level |
| irq_req | output | 17 | Per-flag request lines |

## Verification
The bench builds the block with its default parameters: a 4-bit level, which gives a 17-flag vector, and a timer limit of 14. It sweeps all sixteen level values against a fully set vector. This reaches the index-equals-level boundary of every ordinary flag, and the 13/14 step of the timer flags. Directed cycles put each timer pulse against a same-cycle clear or load of its own flag. A long random stretch mixes all four operation codes with level writes.

// File: rtl/softint_pkg.sv
// Shared types for the soft interrupt pending register.
package softint_pkg;

    // Operation selected by a software write to the pending vector.
    typedef enum logic [1:0] {
        SW_LOAD = 2'd0,
        SW_CLR  = 2'd1,
        SW_SET  = 2'd2,
        SW_NOP  = 2'd3
    } sw_op_e;

endpackage

// File: rtl/softint_pend_reg.sv
// Pending flag register.
// Applies one software operation (load, clear-by-mask, set-by-mask) per
// cycle, then ORs in the hardware timer-match pulses so that they win over
// any same-cycle software change. Assumes a synchronous active-low reset.
module softint_pend_reg
    import softint_pkg::*;
#(
    parameter int PEND_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  sw_op_e            wr_op,
    input  logic [PEND_W-1:0] wr_data,
    input  logic              tick_hit,
    input  logic              stick_hit,
    output logic [PEND_W-1:0] pend_q
);

    localparam int TOP_BIT = PEND_W - 1;

    logic [PEND_W-1:0] sw_next;
    logic [PEND_W-1:0] hw_mask;
    logic [PEND_W-1:0] pend_d;

    // Value after the software operation of this cycle.
    always_comb begin
        sw_next = pend_q;
        if (wr_en) begin
            case (wr_op)
                SW_LOAD: sw_next = wr_data;
                SW_CLR:  sw_next = pend_q & ~wr_data;
                SW_SET:  sw_next = pend_q | wr_data;
                default: sw_next = pend_q;
            endcase
        end
    end

    // Hardware match pulses, placed on the two timer flags.
    always_comb begin
        hw_mask          = '0;
        hw_mask[0]       = tick_hit;
        hw_mask[TOP_BIT] = stick_hit;
    end

    // Hardware sets take priority over software clears and loads.
    assign pend_d = sw_next | hw_mask;

    // Storage for the pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

endmodule

// File: rtl/softint_pil_reg.sv
// Processor interrupt level register.
// Loads a new level on a write strobe, otherwise holds. Assumes a
// synchronous active-low reset that returns the level to zero.
module softint_pil_reg #(
    parameter int PIL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PIL_W-1:0] wr_data,
    output logic [PIL_W-1:0] pil_q
);

    // Storage for the level.
    always_ff @(posedge clk) begin
        if (!rst_n)     pil_q <= '0;
        else if (wr_en) pil_q <= wr_data;
    end

endmodule

// File: rtl/softint_req_gate.sv
// Request gating.
// Turns the stored flags and level into level-sensitive request lines.
// The two end flags (timer matches) compare the level against a fixed
// limit. Every other flag compares its own index against the level.
// Purely combinational: assumes registered inputs.
module softint_req_gate #(
    parameter int PIL_W       = 4,
    parameter int TIMER_LIMIT = 14,
    parameter int PEND_W      = (1 << PIL_W) + 1
) (
    input  logic [PEND_W-1:0] pend,
    input  logic [PIL_W-1:0]  pil,
    output logic [PEND_W-1:0] req
);

    localparam int CMP_W = PIL_W + 1;
    localparam logic [CMP_W-1:0] LIMIT = CMP_W'(TIMER_LIMIT);

    logic [CMP_W-1:0] pil_ext;
    assign pil_ext = {1'b0, pil};

    for (genvar k = 0; k < PEND_W; k++) begin : g_bit
        if (k == 0 || k == PEND_W - 1) begin : g_timer
            // Timer flag: fixed threshold on the level.
            assign req[k] = pend[k] && (pil_ext < LIMIT);
        end else begin : g_level
            localparam logic [CMP_W-1:0] IDX = CMP_W'(k);
            // Ordinary flag: index must exceed the level.
            assign req[k] = pend[k] && (IDX > pil_ext);
        end
    end

endmodule

// File: rtl/softint_ctrl.sv
// Soft interrupt pending register, top level.
// Ties together the flag register, the level register and the request
// gating. The vector width follows from the level width: one flag per
// level plus a top timer flag. Synchronous active-low reset.
module softint_ctrl
    import softint_pkg::*;
#(
    parameter int PIL_W       = 4,
    parameter int TIMER_LIMIT = 14,
    parameter int PEND_W      = (1 << PIL_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr_en,
    input  logic [1:0]        sw_wr_op,
    input  logic [PEND_W-1:0] sw_wr_data,
    input  logic              pil_wr_en,
    input  logic [PIL_W-1:0]  pil_wr_data,
    input  logic              tick_hit,
    input  logic              stick_hit,
    output logic [PEND_W-1:0] pend_rd,
    output logic [PIL_W-1:0]  pil_rd,
    output logic [PEND_W-1:0] irq_req
);

    sw_op_e            op;
    logic [PEND_W-1:0] pend_q;
    logic [PIL_W-1:0]  pil_q;

    // Map the raw operation code onto the shared type.
    assign op = sw_op_e'(sw_wr_op);

    softint_pend_reg #(.PEND_W(PEND_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (sw_wr_en),
        .wr_op     (op),
        .wr_data   (sw_wr_data),
        .tick_hit  (tick_hit),
        .stick_hit (stick_hit),
        .pend_q    (pend_q)
    );

    softint_pil_reg #(.PIL_W(PIL_W)) u_pil (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pil_wr_en),
        .wr_data (pil_wr_data),
        .pil_q   (pil_q)
    );

    softint_req_gate #(
        .PIL_W       (PIL_W),
        .TIMER_LIMIT (TIMER_LIMIT),
        .PEND_W      (PEND_W)
    ) u_gate (
        .pend (pend_q),
        .pil  (pil_q),
        .req  (irq_req)
    );

    assign pend_rd = pend_q;
    assign pil_rd  = pil_q;

endmodule

// File: rtl/softint_ctrl_chk.sv
// Assertion checker for softint_ctrl, attached with bind.
// Observes ports only. Assumes a synchronous active-low reset.
module softint_ctrl_chk #(
    parameter int PIL_W       = 4,
    parameter int TIMER_LIMIT = 14,
    parameter int PEND_W      = (1 << PIL_W) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_wr_en,
    input logic [1:0]        sw_wr_op,
    input logic [PEND_W-1:0] sw_wr_data,
    input logic              pil_wr_en,
    input logic [PIL_W-1:0]  pil_wr_data,
    input logic              tick_hit,
    input logic              stick_hit,
    input logic [PEND_W-1:0] pend_rd,
    input logic [PIL_W-1:0]  pil_rd,
    input logic [PEND_W-1:0] irq_req
);

    localparam int TOP = PEND_W - 1;

    // R1: reset empties the vector and the level.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (pend_rd == '0 && pil_rd == '0));

    // R3: clear by mask, with no hardware pulse in the same cycle.
    assert_clear_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_en && sw_wr_op == 2'd1 && !tick_hit && !stick_hit)
        |=> pend_rd == ($past(pend_rd) & ~$past(sw_wr_data)));

    // R4: set by mask.
    assert_set_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_en && sw_wr_op == 2'd2)
        |=> (pend_rd & $past(sw_wr_data | pend_rd)) == $past(sw_wr_data | pend_rd));

    // R5: the reserved operation code changes nothing.
    assert_nop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_en && sw_wr_op == 2'd3 && !tick_hit && !stick_hit)
        |=> $stable(pend_rd));

    // R8: timer pulses always set their flag.
    assert_tick_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_hit |=> pend_rd[0]);
    assert_stick_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stick_hit |=> pend_rd[TOP]);

    // R9: a level write is stored.
    assert_pil_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pil_wr_en |=> pil_rd == $past(pil_wr_data));

    // R7: timer flags gated by the fixed limit.
    assert_timer_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req[0] == (pend_rd[0] && (int'(pil_rd) < TIMER_LIMIT)));
    assert_timer_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req[TOP] == (pend_rd[TOP] && (int'(pil_rd) < TIMER_LIMIT)));

    // R6: each ordinary flag gated by its index against the level.
    for (genvar k = 1; k < TOP; k++) begin : g_lvl
        assert_level_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[k] == (pend_rd[k] && (k > int'(pil_rd))));
    end

endmodule

bind softint_ctrl softint_ctrl_chk #(
    .PIL_W       (PIL_W),
    .TIMER_LIMIT (TIMER_LIMIT),
    .PEND_W      (PEND_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_wr_en    (sw_wr_en),
    .sw_wr_op    (sw_wr_op),
    .sw_wr_data  (sw_wr_data),
    .pil_wr_en   (pil_wr_en),
    .pil_wr_data (pil_wr_data),
    .tick_hit    (tick_hit),
    .stick_hit   (stick_hit),
    .pend_rd     (pend_rd),
    .pil_rd      (pil_rd),
    .irq_req     (irq_req)
);

// File: tb/softint_ctrl_bench.sv
`timescale 1ns/1ps
// Bench for softint_ctrl: a behavioural model stepped once per clock and
// compared with every output after each edge.
module softint_ctrl_bench;

    localparam int PIL_W  = 4;
    localparam int LIMIT  = 14;
    localparam int PEND_W = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sw_wr_en = 1'b0;
    logic [1:0]        sw_wr_op = 2'd0;
    logic [PEND_W-1:0] sw_wr_data = '0;
    logic              pil_wr_en = 1'b0;
    logic [PIL_W-1:0]  pil_wr_data = '0;
    logic              tick_hit = 1'b0;
    logic              stick_hit = 1'b0;
    logic [PEND_W-1:0] pend_rd;
    logic [PIL_W-1:0]  pil_rd;
    logic [PEND_W-1:0] irq_req;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // Model state.
    int m_pend = 0;
    int m_pil  = 0;

    always #2 clk = ~clk;

    softint_ctrl u_softint_ctrl (
        .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_op(sw_wr_op),
        .sw_wr_data(sw_wr_data), .pil_wr_en(pil_wr_en), .pil_wr_data(pil_wr_data),
        .tick_hit(tick_hit), .stick_hit(stick_hit), .pend_rd(pend_rd),
        .pil_rd(pil_rd), .irq_req(irq_req)
    );

    function automatic int model_req();
        int r = 0;
        for (int b = 0; b < PEND_W; b++) begin
            if (((m_pend >> b) & 1) == 1) begin
                if (b == 0 || b == PEND_W - 1) begin
                    if (m_pil < LIMIT) r |= (1 << b);
                end else if (b > m_pil) begin
                    r |= (1 << b);
                end
            end
        end
        return r;
    endfunction

    task automatic compare(string tag);
        int er = model_req();
        vectors++;
        if (int'(pend_rd) != m_pend || int'(pil_rd) != m_pil) begin
            errors++;
            $display("FAIL %s R10 state: pend=%h pil=%0d expected pend=%h pil=%0d",
                     tag, pend_rd, pil_rd, m_pend, m_pil);
        end
        vectors++;
        if (int'(irq_req) != er) begin
            errors++;
            $display("FAIL R6 R7 R9 (%s) requests: got %h expected %h", tag, irq_req, er);
        end
    endtask

    // One clock: drive at the falling edge, step the model at the rising
    // edge, compare at the next falling edge.
    task automatic step(input bit rn, input bit en, input int op, input int data,
                        input bit pen, input int pd, input bit th, input bit sh,
                        input string tag);
        sw_wr_en    = en;
        sw_wr_op    = 2'(op);
        sw_wr_data  = PEND_W'(data);
        pil_wr_en   = pen;
        pil_wr_data = PIL_W'(pd);
        tick_hit    = th;
        stick_hit   = sh;
        rst_n       = rn;
        @(posedge clk);
        if (!rn) begin
            m_pend = 0;
            m_pil  = 0;
        end else begin
            if (en) begin
                case (op)
                    0: m_pend = data & 'h1FFFF;
                    1: m_pend = m_pend & ~data & 'h1FFFF;
                    2: m_pend = (m_pend | data) & 'h1FFFF;
                    default: ;
                endcase
            end
            if (th) m_pend |= 1;
            if (sh) m_pend |= (1 << 16);
            if (pen) m_pil = pd & 'hF;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        @(negedge clk);
        step(0, 1, 0, 'h1FFFF, 1, 5, 1, 1, "R1");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
        // Load and readback.
        step(1, 1, 0, 'h0A5A5, 0, 0, 0, 0, "R2");
        step(1, 1, 0, 'h1FFFF, 0, 0, 0, 0, "R2");
        // Clear and set by mask.
        step(1, 1, 1, 'h0F0F1, 0, 0, 0, 0, "R3");
        step(1, 1, 2, 'h00101, 0, 0, 0, 0, "R4");
        // Reserved code.
        step(1, 1, 3, 'h00000, 0, 0, 0, 0, "R5");
        // Level sweep with all flags set.
        step(1, 1, 0, 'h1FFFF, 0, 0, 0, 0, "R2");
        for (int p = 0; p < 16; p++) step(1, 0, 0, 0, 1, p, 0, 0, "R6 R7 R9");
        for (int p = 15; p >= 0; p--) step(1, 0, 0, 0, 1, p, 0, 0, "R6 R7 R9");
        // Timer pulses against same-cycle clear and load.
        step(1, 1, 1, 'h1FFFF, 0, 0, 1, 1, "R8");
        step(1, 1, 0, 'h00000, 0, 0, 1, 0, "R8");
        step(1, 1, 0, 'h00000, 0, 0, 0, 1, "R8");
        step(1, 1, 1, 'h10001, 1, 13, 0, 0, "R3");
        step(1, 1, 2, 'h10001, 0, 0, 0, 0, "R7");
        step(1, 0, 0, 0, 1, 14, 0, 0, "R7");
        // Simultaneous flag and level write.
        step(1, 1, 0, 'h08000, 1, 15, 0, 0, "R9");
        step(1, 1, 0, 'h08000, 1, 14, 0, 0, "R9");
        // Random mix.
        for (int i = 0; i < 400; i++) begin
            step(1, 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 'h1FFFF)), 1'($urandom_range(0, 1)),
                 int'($urandom_range(0, 15)), ($urandom_range(0, 7) == 0),
                 ($urandom_range(0, 7) == 0), "R2 R3 R4 R5 R8");
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule